// File: doc/BRIEF.md
# Immediate-Offset Integer Load Unit

This unit executes one integer load whose address is formed from a base register and a constant carried in the 32-bit instruction word. It accepts an instruction over a valid/ready handshake and decodes it in the acceptance cycle. In that same cycle it reads the base register through a combinational register-file read port, or takes the stack pointer when the base index is 31. From this it computes the effective address.

The unit then holds a memory read request until the memory accepts it. It waits for the read response. In the response cycle it drives the destination register write and, for the two indexed forms, a second write that returns the updated address to the base register.

Three addressing forms are handled:
- Post-index accesses at the unmodified base, then writes back base plus a signed 9-bit offset.
- Pre-index accesses at base plus the signed offset and writes that same sum back.
- Scaled unsigned offset accesses at base plus a 12-bit immediate shifted left by the size code. It never writes back.

When an indexed form names the same general register as both base and destination, the default policy drops the base write so the loaded value survives. The parameter `OVERLAP_UNDEF` instead turns that case into an undefined-instruction fault.

Top module: `ldimm_unit`

## Requirements
- R1: A word that does not match all of the following is undefined: bit31=1, bits29..27=111, bit26=0, bits23..22=01, and either (bits25..24=00, bit21=0, bits11..10 in {01,11}) or bits25..24=01. For an undefined word, `fault_undef` is high for exactly the cycle after acceptance, with no memory request and no register write.
- R2: Pre-index (bits11..10=11) reads at base + sign-extended bits20..12, and writes that sum back to the base register.
- R3: Post-index (bits11..10=01) reads at the unmodified base, and writes back base + sign-extended bits20..12.
- R4: Unsigned offset (bits25..24=01) reads at base + (bits21..10 zero-extended, shifted left by the size code), and raises no base write.
- R5: Bit 30 selects width. With bit 30 = 0, `mem_req_size`=2, `rd_wide`=0, and `rd_data` is the low 32 bits of the response, zero-extended. With bit 30 = 1, `mem_req_size`=3, `rd_wide`=1, and `rd_data` is the full response.
- R6: Base index 31 (bits9..5) takes the base value from `sp_in`, and its writeback is flagged with `wb_is_sp`=1.
- R7: With base index 31 and `sp_in[3:0]`≠0, `fault_align` is high for exactly the cycle after acceptance, with no memory request and no register write.
- R8: `mem_req_valid` rises the cycle after acceptance. Address and size stay unchanged until the cycle in which `mem_req_ready` is seen high.
- R9: `rd_we` and `wb_we` are high only in the cycle where `mem_rsp_valid` is high after a request was accepted. `rd_idx` equals bits4..0.
- R10: With the default policy, an indexed form whose base equals its destination (not 31) performs the destination write and suppresses the base write.
- R11: After reset, `ins_ready`=1 and all valid, write and fault outputs are 0.
- R12: `ins_ready` is 0 from the cycle after acceptance of a legal, fault-free load until the response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Unit idle and able to take an instruction |
| ins_word | input | 32 | Instruction encoding |
| rf_rd_idx | output | 5 | Register-file read index (base field) |
| rf_rd_data | input | AW | Register value at `rf_rd_idx`, same cycle |
| sp_in | input | AW | Current stack pointer |
| mem_req_valid | output | 1 | Read request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Byte address of the read |
| mem_req_size | output | 2 | log2 of access bytes (2 or 3) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| rd_we | output | 1 | Destination register write |
| rd_idx | output | 5 | Destination register index |
| rd_wide | output | 1 | 1: full 64-bit write, 0: 32-bit view |
| rd_data | output | DW | Zero-extended load result |
| wb_we | output | 1 | Base register writeback |
| wb_is_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | AW | Updated base address |
| fault_undef | output | 1 | Undefined-instruction pulse |
| fault_align | output | 1 | Stack-pointer misalignment pulse |

## Verification
The bench builds the unit with its defaults: 64-bit address and data, a 16-byte stack alignment check, and writeback suppression on overlap. These defaults bring the suppression path and the 4-bit alignment test within reach. Random legal encodings of all three forms are mixed with single-bit corruptions of the fixed fields, with random memory stall and response latencies. Directed cases cover the offset extremes (-256, +255, the largest scaled immediate), base 31 both aligned and misaligned, and the overlap case for a general register and for register 31.

// File: rtl/ldimm_pkg.sv
package ldimm_pkg;

    typedef enum logic [1:0] {
        FORM_POST = 2'd0,
        FORM_PRE  = 2'd1,
        FORM_UOFF = 2'd2,
        FORM_NONE = 2'd3
    } form_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_REQ  = 2'd1,
        PH_RSP  = 2'd2
    } phase_e;

    typedef struct packed {
        logic        legal;
        form_e       form;
        logic        wide;
        logic [4:0]  base;
        logic [4:0]  dest;
        logic [8:0]  simm;
        logic [11:0] uimm;
    } dec_t;

endpackage

// File: rtl/ldimm_decode.sv
module ldimm_decode
    import ldimm_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    logic fixed_ok;

    always_comb begin
        fixed_ok = word[31] && (word[29:27] == 3'b111) && !word[26]
                   && (word[23:22] == 2'b01);
        dec       = '0;
        dec.form  = FORM_NONE;
        dec.wide  = word[30];
        dec.base  = word[9:5];
        dec.dest  = word[4:0];
        dec.simm  = word[20:12];
        dec.uimm  = word[21:10];
        if (fixed_ok) begin
            if (word[25:24] == 2'b00 && !word[21]) begin
                if (word[11:10] == 2'b01)      dec.form = FORM_POST;
                else if (word[11:10] == 2'b11) dec.form = FORM_PRE;
            end else if (word[25:24] == 2'b01) begin
                dec.form = FORM_UOFF;
            end
        end
        dec.legal = (dec.form != FORM_NONE);
    end
endmodule

// File: rtl/ldimm_agen.sv
module ldimm_agen
    import ldimm_pkg::*;
#(
    parameter int AW = 64
) (
    input  dec_t          dec,
    input  logic [AW-1:0] base_val,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] upd_addr
);
    logic [AW-1:0] sext_off;
    logic [AW-1:0] scaled_off;
    logic [1:0]    shamt;

    always_comb begin
        shamt      = dec.wide ? 2'd3 : 2'd2;
        sext_off   = {{(AW-9){dec.simm[8]}}, dec.simm};
        scaled_off = {{(AW-12){1'b0}}, dec.uimm} << shamt;
        upd_addr   = base_val + sext_off;
        case (dec.form)
            FORM_PRE:  acc_addr = upd_addr;
            FORM_POST: acc_addr = base_val;
            default:   acc_addr = base_val + scaled_off;
        endcase
    end
endmodule

// File: rtl/ldimm_unit.sv
module ldimm_unit
    import ldimm_pkg::*;
#(
    parameter int       AW            = 64,
    parameter int       DW            = 64,
    parameter int       SP_ALIGN_LG2  = 4,
    parameter bit       OVERLAP_UNDEF = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_valid,
    output logic          ins_ready,
    input  logic [31:0]   ins_word,
    output logic [4:0]    rf_rd_idx,
    input  logic [AW-1:0] rf_rd_data,
    input  logic [AW-1:0] sp_in,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    output logic [1:0]    mem_req_size,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          rd_we,
    output logic [4:0]    rd_idx,
    output logic          rd_wide,
    output logic [DW-1:0] rd_data,
    output logic          wb_we,
    output logic          wb_is_sp,
    output logic [4:0]    wb_idx,
    output logic [AW-1:0] wb_data,
    output logic          fault_undef,
    output logic          fault_align
);
    localparam int         HALF    = DW / 2;
    localparam logic [4:0] SP_IDX  = 5'd31;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_DBL  = 2'd3;

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] addr;
        logic [1:0]    size;
        logic          wide;
        logic [4:0]    dest;
        logic          wb_en;
        logic          wb_sp;
        logic [4:0]    wb_idx;
        logic [AW-1:0] wb_addr;
        logic          f_undef;
        logic          f_align;
    } ctx_t;

    localparam ctx_t CTX_RESET = '{phase: PH_IDLE, default: '0};

    dec_t          dec;
    logic [AW-1:0] base_val;
    logic [AW-1:0] acc_addr;
    logic [AW-1:0] upd_addr;
    logic          accept;
    logic          wants_wb;
    logic          overlap;
    logic          sp_misaligned;
    ctx_t          ctx_d, ctx_q;

    ldimm_decode u_dec (
        .word (ins_word),
        .dec  (dec)
    );

    assign rf_rd_idx = dec.base;
    assign base_val  = (dec.base == SP_IDX) ? sp_in : rf_rd_data;

    ldimm_agen #(.AW(AW)) u_agen (
        .dec      (dec),
        .base_val (base_val),
        .acc_addr (acc_addr),
        .upd_addr (upd_addr)
    );

    assign ins_ready = (ctx_q.phase == PH_IDLE);
    assign accept    = ins_valid && ins_ready;

    always_comb begin
        wants_wb      = (dec.form == FORM_POST) || (dec.form == FORM_PRE);
        overlap       = wants_wb && (dec.base == dec.dest) && (dec.base != SP_IDX);
        sp_misaligned = (dec.base == SP_IDX) && (sp_in[SP_ALIGN_LG2-1:0] != '0);

        ctx_d         = ctx_q;
        ctx_d.f_undef = 1'b0;
        ctx_d.f_align = 1'b0;
        case (ctx_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    if (!dec.legal || (overlap && OVERLAP_UNDEF)) begin
                        ctx_d.f_undef = 1'b1;
                    end else if (sp_misaligned) begin
                        ctx_d.f_align = 1'b1;
                    end else begin
                        ctx_d.phase   = PH_REQ;
                        ctx_d.addr    = acc_addr;
                        ctx_d.size    = dec.wide ? SZ_DBL : SZ_WORD;
                        ctx_d.wide    = dec.wide;
                        ctx_d.dest    = dec.dest;
                        ctx_d.wb_en   = wants_wb && !overlap;
                        ctx_d.wb_sp   = (dec.base == SP_IDX);
                        ctx_d.wb_idx  = dec.base;
                        ctx_d.wb_addr = upd_addr;
                    end
                end
            end
            PH_REQ: begin
                if (mem_req_ready) ctx_d.phase = PH_RSP;
            end
            PH_RSP: begin
                if (mem_rsp_valid) ctx_d.phase = PH_IDLE;
            end
            default: ctx_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= CTX_RESET;
        else        ctx_q <= ctx_d;
    end

    assign mem_req_valid = (ctx_q.phase == PH_REQ);
    assign mem_req_addr  = ctx_q.addr;
    assign mem_req_size  = ctx_q.size;

    assign rd_we    = (ctx_q.phase == PH_RSP) && mem_rsp_valid;
    assign rd_idx   = ctx_q.dest;
    assign rd_wide  = ctx_q.wide;
    assign rd_data  = ctx_q.wide ? mem_rsp_data
                                 : {{(DW-HALF){1'b0}}, mem_rsp_data[HALF-1:0]};
    assign wb_we    = rd_we && ctx_q.wb_en;
    assign wb_is_sp = ctx_q.wb_sp;
    assign wb_idx   = ctx_q.wb_idx;
    assign wb_data  = ctx_q.wb_addr;

    assign fault_undef = ctx_q.f_undef;
    assign fault_align = ctx_q.f_align;

    // R8: request held steady until the memory takes it
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size));

    // R9: register writes only alongside a read response
    a_r9_write_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_we || wb_we) |-> mem_rsp_valid && !mem_req_valid);

    // R10: a general-register base write never collides with the destination
    a_r10_no_overlap_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we && !wb_is_sp |-> wb_idx != rd_idx);

    // R12: no new instruction while a request is outstanding
    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !ins_ready);

    // R1 and R7: a fault cycle carries no memory or register activity
    a_r1_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_undef || fault_align) |-> !mem_req_valid && !rd_we && !wb_we);

    // R5: only word or doubleword size codes are issued
    a_r5_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_size == SZ_WORD) || (mem_req_size == SZ_DBL));

    // R8: request appears only one cycle after an accepted instruction
    a_r8_req_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(ins_valid) && $past(ins_ready));
endmodule

// File: tb/ldimm_unit_test.sv
`timescale 1ns/1ps
module ldimm_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [31:0] ins_word = '0;
    logic [4:0]  rf_rd_idx;
    logic [63:0] rf_rd_data;
    logic [63:0] sp_in = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rd_we, rd_wide, wb_we, wb_is_sp, fault_undef, fault_align;
    logic [4:0]  rd_idx, wb_idx;
    logic [63:0] rd_data, wb_data;

    logic [63:0] regs [32];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_idx];

    ldimm_unit uut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .sp_in(sp_in),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_wide(rd_wide), .rd_data(rd_data),
        .wb_we(wb_we), .wb_is_sp(wb_is_sp), .wb_idx(wb_idx), .wb_data(wb_data),
        .fault_undef(fault_undef), .fault_align(fault_align)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // 0 undefined, 1 post-index, 2 pre-index, 3 unsigned offset
    function automatic int kind_of(input logic [31:0] w);
        if (!(w[31] && w[29:27] == 3'b111 && !w[26] && w[23:22] == 2'b01)) return 0;
        if (w[25:24] == 2'b01) return 3;
        if (w[25:24] != 2'b00 || w[21]) return 0;
        if (w[11:10] == 2'b01) return 1;
        if (w[11:10] == 2'b11) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] mk_idx(input bit pre, input bit wide,
            input logic [8:0] imm, input logic [4:0] n, input logic [4:0] t);
        return {1'b1, wide, 3'b111, 1'b0, 2'b00, 2'b01, 1'b0, imm,
                pre ? 2'b11 : 2'b01, n, t};
    endfunction

    function automatic logic [31:0] mk_uoff(input bit wide, input logic [11:0] imm,
            input logic [4:0] n, input logic [4:0] t);
        return {1'b1, wide, 3'b111, 1'b0, 2'b01, 2'b01, imm, n, t};
    endfunction

    task automatic run_one(input logic [31:0] w, input logic [63:0] sp);
        int          k;
        logic [4:0]  n, t;
        logic [63:0] base, sx, ea, upd, data, expd;
        bit          ovl, exp_wb;
        string       tag;
        k = kind_of(w);
        n = w[9:5];
        t = w[4:0];
        base = (n == 5'd31) ? sp : regs[n];
        sx   = {{55{w[20]}}, w[20:12]};
        upd  = base + sx;
        ovl  = (k == 1 || k == 2) && n == t && n != 5'd31;
        @(negedge clk);
        sp_in = sp;
        ins_word = w;
        ins_valid = 1'b1;
        chk(ins_ready == 1'b1, "R12 ready when idle", 64'(ins_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        if (k == 0) begin
            chk(fault_undef == 1'b1, "R1 undef pulse", 64'(fault_undef), 64'd1);
            chk(!mem_req_valid && !rd_we && !wb_we, "R1 no side effect",
                64'(mem_req_valid), 64'd0);
            @(negedge clk);
            chk(fault_undef == 1'b0, "R1 pulse one cycle", 64'(fault_undef), 64'd0);
            chk(!mem_req_valid, "R1 no request later", 64'(mem_req_valid), 64'd0);
        end else if (n == 5'd31 && sp[3:0] != 4'd0) begin
            chk(fault_align == 1'b1, "R7 align pulse", 64'(fault_align), 64'd1);
            chk(!mem_req_valid && !rd_we && !wb_we, "R7 no side effect",
                64'(mem_req_valid), 64'd0);
            @(negedge clk);
            chk(fault_align == 1'b0, "R7 pulse one cycle", 64'(fault_align), 64'd0);
            chk(!mem_req_valid, "R7 no request later", 64'(mem_req_valid), 64'd0);
        end else begin
            if (k == 2) begin ea = upd; tag = "R2 pre-index addr"; end
            else if (k == 1) begin ea = base; tag = "R3 post-index addr"; end
            else begin
                ea = base + ({52'd0, w[21:10]} << (w[30] ? 3 : 2));
                tag = "R4 unsigned offset addr";
            end
            if (n == 5'd31) tag = {tag, " R6 sp base"};
            chk(mem_req_valid == 1'b1, "R8 request raised", 64'(mem_req_valid), 64'd1);
            chk(mem_req_addr == ea, tag, mem_req_addr, ea);
            chk(mem_req_size == (w[30] ? 2'd3 : 2'd2), "R5 size code",
                64'(mem_req_size), w[30] ? 64'd3 : 64'd2);
            chk(ins_ready == 1'b0, "R12 busy", 64'(ins_ready), 64'd0);
            repeat ($urandom_range(0, 3)) begin
                @(negedge clk);
                chk(mem_req_valid && mem_req_addr == ea, "R8 held while stalled",
                    mem_req_addr, ea);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk(!mem_req_valid, "R8 request dropped after accept",
                64'(mem_req_valid), 64'd0);
            repeat ($urandom_range(0, 3)) begin
                chk(!rd_we && !wb_we, "R9 no write before response", 64'(rd_we), 64'd0);
                chk(ins_ready == 1'b0, "R12 busy awaiting data", 64'(ins_ready), 64'd0);
                @(negedge clk);
            end
            data = {$urandom, $urandom};
            mem_rsp_data = data;
            mem_rsp_valid = 1'b1;
            #1;
            expd = w[30] ? data : {32'd0, data[31:0]};
            chk(rd_we == 1'b1, "R9 write on response", 64'(rd_we), 64'd1);
            chk(rd_idx == t, "R9 dest index", 64'(rd_idx), 64'(t));
            chk(rd_data == expd, "R5 zero-extended data", rd_data, expd);
            chk(rd_wide == w[30], "R5 width flag", 64'(rd_wide), 64'(w[30]));
            exp_wb = (k != 3) && !ovl;
            chk(wb_we == exp_wb, ovl ? "R10 overlap suppress" :
                (k == 3 ? "R4 no writeback" : "R3 writeback enable"),
                64'(wb_we), 64'(exp_wb));
            if (exp_wb) begin
                chk(wb_data == upd, k == 2 ? "R2 writeback value" : "R3 writeback value",
                    wb_data, upd);
                chk(wb_is_sp == (n == 5'd31), "R6 sp writeback flag",
                    64'(wb_is_sp), 64'(n == 5'd31));
                chk(wb_idx == n, "R3 writeback index", 64'(wb_idx), 64'(n));
                if (n != 5'd31) regs[n] = upd;
            end
            if (t != 5'd31) regs[t] = expd;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(!rd_we && !wb_we, "R9 single write cycle", 64'(rd_we), 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R12 watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int          seed_init;
        logic [31:0] w;
        logic [4:0]  n, t;
        logic [63:0] sp;
        seed_init = $urandom(32'h5eed_0417);
        for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ins_ready == 1'b1, "R11 reset ready", 64'(ins_ready), 64'd1);
        chk(!mem_req_valid && !rd_we && !wb_we && !fault_undef && !fault_align,
            "R11 reset outputs quiet", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ins_ready == 1'b1 && !mem_req_valid, "R11 idle after reset",
            64'(ins_ready), 64'd1);

        // directed corners
        run_one(mk_idx(1'b1, 1'b1, 9'h100, 5'd3, 5'd4), 64'h0);      // R2 -256
        run_one(mk_idx(1'b0, 1'b0, 9'h0FF, 5'd5, 5'd6), 64'h0);      // R3 +255, R5 32-bit
        run_one(mk_uoff(1'b1, 12'hFFF, 5'd7, 5'd8), 64'h0);          // R4 max scaled
        run_one(mk_uoff(1'b0, 12'hFFF, 5'd9, 5'd10), 64'h0);         // R4 word scale
        run_one(mk_idx(1'b1, 1'b1, 9'h010, 5'd31, 5'd2), 64'h1000);  // R6 aligned sp
        run_one(mk_idx(1'b0, 1'b1, 9'h1F0, 5'd31, 5'd2), 64'h1008);  // R7 misaligned
        run_one(mk_uoff(1'b1, 12'h001, 5'd31, 5'd1), 64'h2004);      // R7 uoff on sp
        run_one(mk_idx(1'b1, 1'b1, 9'h008, 5'd12, 5'd12), 64'h0);    // R10 overlap
        run_one(mk_idx(1'b0, 1'b0, 9'h1F8, 5'd13, 5'd13), 64'h0);    // R10 overlap post
        run_one(mk_idx(1'b1, 1'b1, 9'h020, 5'd31, 5'd31), 64'h3000); // R6 n=t=31 wb kept
        run_one(32'h0000_0000, 64'h0);                               // R1 all zero
        run_one(mk_idx(1'b0, 1'b1, 9'h0, 5'd1, 5'd2) ^ 32'h0000_0400, 64'h0); // R1 bits11..10=00

        // random mix
        for (int i = 0; i < 400; i++) begin
            n = 5'($urandom_range(0, 31));
            t = ($urandom_range(0, 7) == 0) ? n : 5'($urandom_range(0, 31));
            sp = {$urandom, $urandom};
            if ($urandom_range(0, 1) == 1) sp[3:0] = 4'd0;
            case ($urandom_range(0, 3))
                0: w = mk_idx(1'b0, 1'($urandom), 9'($urandom), n, t);
                1: w = mk_idx(1'b1, 1'($urandom), 9'($urandom), n, t);
                2: w = mk_uoff(1'($urandom), 12'($urandom), n, t);
                default: begin
                    int pick;
                    w = mk_idx(1'($urandom), 1'($urandom), 9'($urandom), n, t);
                    pick = $urandom_range(0, 9);
                    case (pick)
                        0: w[31] = ~w[31];
                        1: w[29] = ~w[29];
                        2: w[28] = ~w[28];
                        3: w[27] = ~w[27];
                        4: w[26] = ~w[26];
                        5: w[23] = ~w[23];
                        6: w[22] = ~w[22];
                        7: w[25] = ~w[25];
                        8: w[21] = ~w[21];
                        default: w[10] = ~w[10];
                    endcase
                end
            endcase
            run_one(w, sp);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule